// File: doc/BRIEF.md
# Speculative Gshare Direction Predictor with History Checkpoints

This block predicts whether a conditional branch will be taken. Each cycle the fetch stage offers a slice of the program counter. The block combines that slice by exclusive-OR with a global history of recent branch directions. The result selects one 2-bit saturating counter in a pattern table, and the counter's upper bit is the prediction.

When a prediction is accepted, the history advances at once, using the predicted direction. This lets back-to-back branches see each other's directions before either one resolves. For every accepted prediction, a snapshot of the history is placed in an in-order checkpoint queue. The snapshot already holds the opposite of the predicted direction shifted in.

Branches retire through a commit port. Each commit carries the actual direction, a misprediction flag and the table index that was used at prediction time. The matching counter is trained on every commit. A correct commit removes the oldest checkpoint. A mispredicted commit copies that checkpoint into the live history and discards every younger checkpoint.

Top module: `gshare_spec_repair`

## Requirements
- R1: After reset the history is all zeros, every counter holds weakly-not-taken (01), so `pred_taken` is 0 for any PC slice, and `pred_ready` is 1.
- R2: `pred_index` equals `ghist` XOR `pc_slice`, combinationally in the same cycle.
- R3: `pred_taken` is bit 1 of the counter selected by `pred_index`. Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R4: A prediction is accepted when `pred_valid` and `pred_ready` are both high. After an accepted prediction (with no mispredicted commit in that cycle), `ghist` on the next cycle equals the old history shifted left by one, with `pred_taken` in bit 0 and the old top bit dropped.
- R5: Each commit trains the counter at `commit_index`. Taken increments it and not-taken decrements it, saturating at 11 and 00. Two opposite outcomes are therefore needed to flip a strong state's prediction.
- R6: `pred_ready` is low while 8 checkpoints are outstanding. A prediction offered while `pred_ready` is low is ignored and leaves `ghist` unchanged.
- R7: A commit without the misprediction flag removes the oldest checkpoint and does not change `ghist`. Commits arrive only while at least one checkpoint is outstanding.
- R8: A commit with the misprediction flag sets `ghist` to the history that was live at the oldest outstanding prediction, shifted left with the actual direction in bit 0. It also discards all younger checkpoints, so `pred_ready` is 1 on the following cycle.
- R9: If a prediction is accepted in the same cycle as a mispredicted commit, the repair wins. That prediction pushes no checkpoint and does not advance the history.
- R10: A prediction that reads the same counter a commit trains in that cycle sees the counter's value from before the training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Fetch requests a prediction |
| pc_slice | input | HIST_W | Program counter bits starting at the instruction-alignment bit |
| pred_ready | output | 1 | A checkpoint slot is free and a request will be accepted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | HIST_W | Table index used for this prediction, to be returned at commit |
| commit_valid | input | 1 | Oldest outstanding branch resolves this cycle |
| commit_taken | input | 1 | Actual direction of the committing branch |
| commit_mispredict | input | 1 | Committing branch was mispredicted |
| commit_index | input | HIST_W | Table index recorded at prediction time |
| ghist | output | HIST_W | Live speculative global history |

## Verification
Two pairings of functions can fall in one cycle. A prediction can be made while a commit resolves, and the commit may repair or may simply retire. The bench provokes both cases by driving a request and a commit together: once with the commit flagged as mispredicted, and once with the request's PC slice chosen so that it selects the counter the commit is training. A behavioural model with queues steps in lockstep with the design. It compares the index, prediction, ready flag and history every cycle, so a dropped repair, a pushed wrong-path checkpoint or a read of the freshly trained counter shows up on the cycle it occurs.

// File: rtl/gshare_spec_repair.sv
`timescale 1ns/1ps
module gshare_spec_repair #(
  parameter int HIST_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [HIST_W-1:0] pc_slice,
  output logic              pred_ready,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_index,
  input  logic              commit_valid,
  input  logic              commit_taken,
  input  logic              commit_mispredict,
  input  logic [HIST_W-1:0] commit_index,
  output logic [HIST_W-1:0] ghist
);
  localparam int ENTRIES = 1 << HIST_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]        pht  [ENTRIES];
  logic [HIST_W-1:0] snap [DEPTH];
  logic [HIST_W-1:0] ghist_q;
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;
  logic              fire, repair, push, pop;

  assign pred_index = ghist_q ^ pc_slice;
  assign pred_taken = pht[pred_index][1];
  assign pred_ready = (count != CW'(DEPTH));
  assign ghist      = ghist_q;

  assign fire   = pred_valid & pred_ready;
  assign repair = commit_valid & commit_mispredict;
  assign push   = fire & ~repair;
  assign pop    = commit_valid & ~repair;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist_q <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else if (repair) begin
      ghist_q <= snap[head];
      head    <= tail;
      count   <= '0;
    end else begin
      if (push) begin
        ghist_q <= {ghist_q[HIST_W-2:0], pred_taken};
        tail    <= bump(tail);
      end
      if (pop) head <= bump(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) snap[tail] <= {ghist_q[HIST_W-2:0], ~pred_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= 2'b01;
    end else if (commit_valid) begin
      if (commit_taken && pht[commit_index] != 2'b11)
        pht[commit_index] <= pht[commit_index] + 2'b01;
      else if (!commit_taken && pht[commit_index] != 2'b00)
        pht[commit_index] <= pht[commit_index] - 2'b01;
    end
  end

  p_spec_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready && !(commit_valid && commit_mispredict))
    |=> ghist == {$past(ghist[HIST_W-2:0]), $past(pred_taken)});

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready && !commit_valid) |=> $stable(ghist));

  p_commit_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_mispredict && !pred_valid) |=> $stable(ghist));

  p_commit_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> count != '0);

  p_flush_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_mispredict) |=> pred_ready);

  p_repair_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_mispredict) |=> ghist[0] == $past(commit_taken));
endmodule

// File: tb/test_gshare_spec_repair.sv
`timescale 1ns/1ps
module test_gshare_spec_repair;
  localparam int HW = 8;
  localparam int DEPTH = 8;
  localparam int MASK = (1 << HW) - 1;

  logic clk = 0, rst_n = 0;
  logic pred_valid = 0, commit_valid = 0, commit_taken = 0, commit_mispredict = 0;
  logic [HW-1:0] pc_slice = '0, commit_index = '0;
  logic pred_ready, pred_taken;
  logic [HW-1:0] pred_index, ghist;

  always #2 clk = ~clk;

  gshare_spec_repair #(.HIST_W(HW), .DEPTH(DEPTH)) i_gshare_spec_repair (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pc_slice(pc_slice),
    .pred_ready(pred_ready), .pred_taken(pred_taken), .pred_index(pred_index),
    .commit_valid(commit_valid), .commit_taken(commit_taken),
    .commit_mispredict(commit_mispredict), .commit_index(commit_index),
    .ghist(ghist));

  int nchk = 0, nerr = 0;
  int cnt [1 << HW];
  int gm = 0;
  int snapq[$];
  int pidx[$];
  bit ppred[$];

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit pv, input int pcs, input bit cv_in, input bit actual, input string tag);
    int idx, ci, s;
    bit pt, full, cm, cv, fire;
    cv = cv_in && (pidx.size() != 0);
    full = snapq.size() >= DEPTH;
    idx = (gm ^ pcs) & MASK;
    pt = cnt[idx] >= 2;
    ci = 0; cm = 0;
    if (cv) begin ci = pidx[0]; cm = (actual != ppred[0]); end
    pred_valid = pv; pc_slice = pcs[HW-1:0];
    commit_valid = cv; commit_taken = actual; commit_mispredict = cm;
    commit_index = ci[HW-1:0];
    #1;
    check("R2", "pred_index", pred_index, idx);
    check("R3", "pred_taken", pred_taken, pt);
    check("R6", "pred_ready", pred_ready, !full);
    check(tag, "ghist", ghist, gm);
    @(posedge clk);
    fire = pv && !full;
    s = 0;
    if (cv) begin
      if (actual && cnt[ci] < 3) cnt[ci]++;
      else if (!actual && cnt[ci] > 0) cnt[ci]--;
      s = snapq.pop_front();
      void'(pidx.pop_front());
      void'(ppred.pop_front());
    end
    if (cv && cm) begin
      gm = s;
      snapq.delete(); pidx.delete(); ppred.delete();
    end else if (fire) begin
      snapq.push_back(((gm << 1) | (pt ? 0 : 1)) & MASK);
      pidx.push_back(idx);
      ppred.push_back(pt);
      gm = ((gm << 1) | pt) & MASK;
    end
    @(negedge clk);
  endtask

  function automatic bit head_pred();
    return (ppred.size() != 0) ? ppred[0] : 1'b0;
  endfunction

  initial begin
    #(200000 * 4);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << HW); i++) cnt[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state across several PC slices
    step(0, 0, 0, 0, "R1");
    step(0, 8'h5A, 0, 0, "R1");
    step(0, 8'hFF, 0, 0, "R1");
    // R4: back-to-back speculative history updates
    for (int k = 0; k < 5; k++) step(1, k * 37, 0, 0, "R4");
    // R6: fill the queue and keep requesting while full
    for (int k = 0; k < 6; k++) step(1, k * 11 + 3, 0, 0, "R6");
    // R7: correct commits retire without touching history
    for (int k = 0; k < 3; k++) step(0, 0, 1, head_pred(), "R7");
    // R8: misprediction repair and flush
    step(0, 0, 1, !head_pred(), "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 8'h44, 0, 0, "R8");
    // R5: training toward taken, then back to not taken
    for (int k = 0; k < 6; k++) begin
      step(1, 8'h33, 0, 0, "R5");
      step(0, 0, 1, 1, "R5");
    end
    for (int k = 0; k < 6; k++) begin
      step(1, 8'h33, 0, 0, "R5");
      step(0, 0, 1, 0, "R5");
    end
    // R9: prediction in the same cycle as a mispredicted commit
    step(1, 8'h10, 0, 0, "R9");
    step(1, 8'h20, 1, !head_pred(), "R9");
    step(0, 0, 0, 0, "R9");
    // R10: predict the very counter being trained this cycle
    for (int k = 0; k < 5; k++) begin
      step(1, 8'h6C, 0, 0, "R10");
      step(1, (pidx[pidx.size()-1] ^ gm) & MASK, 1, 1, "R10");
      step(0, 0, 0, 0, "R10");
      while (pidx.size() != 0) step(0, 0, 1, head_pred(), "R10");
    end
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bit pv, cv, act;
      pv = ($urandom % 4) != 0;
      cv = ($urandom % 3) == 0;
      act = (($urandom % 4) == 0) ? !head_pred() : head_pred();
      step(pv, $urandom & MASK, cv, act, "R4");
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule